// File: doc/BRIEF.md
# Wiper Position and Recall Controller

This block owns the live tap code of a digitally controlled resistor divider. It decides what that code is after power-up, while the divider is shut down, and when a host writes it. After a reset, the live code sits at mid-scale. On the first clock on which the supply is reported healthy enough to read nonvolatile storage, the live code is reloaded from a stored start-up value. From then on, a host-side bus block can write either the live code, which takes effect on the next clock, or the stored start-up value. A write to the stored value occupies a timed write cycle, and busy is raised for that cycle.

Shutdown is requested either by an active-low pin or by a control-register bit. While it is requested, the block opens the divider ends, grounds the tap and drives the tap select to zero. The live code is held untouched, so leaving shutdown brings back the previous tap. With chip select high and no storage write running, the block reports standby. The stored start-up value has no reset: it survives reset, which stands in for loss of power. Until it has been programmed once, its content is undefined.

Top module: `wiper_recall_ctrl`

## Requirements
- R1: During reset and afterwards, until the first recall, the live code is mid-scale (40h for a 7-bit code), and tap_sel shows 40h when not in shutdown.
- R2: On the first rising clock edge after reset at which supply_ok is high, the stored start-up value is copied into the live code. The copy happens once per reset.
- R3: Outside shutdown, tap_sel equals the live code. Code 00h is the tap nearest ground, code 7Fh is the tap nearest the supply, and the mapping is the identity, so it is monotonic.
- R4: Shutdown is active (shut_o = 1) when sd_pin_n is 0 or sd_bit is 1. While shutdown is active, tap_sel is 00h.
- R5: Shutdown does not change the live code. When shutdown is released, tap_sel shows the code held before shutdown.
- R6: standby is 1 exactly when cs_n is 1 and no storage write is running.
- R7: The stored start-up value keeps its content through reset. A reset during a storage write aborts that write and leaves the old content.
- R8: An accepted write to the stored value holds nv_busy high for NV_CYCLES clocks (8 by default), starting the clock after the write strobe. The new value is stored at the end of that cycle.
- R9: A wr_wiper_en strobe after recall sets the live code to wr_data on the next clock.
- R10: wr_init_en strobes that arrive while nv_busy is high are ignored and do not change the value being stored.
- R11: Before the recall has happened, both write strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (also models power loss) |
| supply_ok | input | 1 | Supply is high enough for a nonvolatile read |
| cs_n | input | 1 | Chip select, active low |
| sd_pin_n | input | 1 | Shutdown pin, active low |
| sd_bit | input | 1 | Shutdown bit from the access control register |
| wr_wiper_en | input | 1 | Write strobe for the live code |
| wr_init_en | input | 1 | Write strobe for the stored start-up value |
| wr_data | input | CODE_W | Data for either write strobe |
| tap_sel | output | CODE_W | Selected tap, 0 in shutdown |
| shut_o | output | 1 | Open the divider ends and ground the tap |
| nv_busy | output | 1 | Storage write cycle running |
| standby | output | 1 | Deselected and idle |

## Verification
The hardest situation to reach from the ports is a reset that lands in the middle of a storage write. That case has to show that the stored value keeps its old content, and it can only be seen through the next recall. The bench first programs a known value and lets that write complete. It then starts a second write, pulses reset partway through the busy window, raises supply_ok, and reads the recalled code on tap_sel. Rejected writes during busy are observed the same way, by a reset and recall after the busy window closes.

// File: rtl/wrc_pkg.sv
package wrc_pkg;
  // Mid-scale code for a given code width.
  function automatic int unsigned mid_code(input int unsigned w);
    return 32'd1 << (w - 1);
  endfunction

  // Tap index for a live code: identity outside shutdown, zero inside.
  function automatic logic tap_bit(input logic code_bit, input logic shut);
    return code_bit & ~shut;
  endfunction
endpackage

// File: rtl/wrc_nv_cell.sv
module wrc_nv_cell #(
  parameter int CODE_W    = 7,
  parameter int NV_CYCLES = 8,
  localparam int CNT_W    = $clog2(NV_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] nv_q,
  output logic [CODE_W-1:0] pend_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              busy,
  output logic              accept,
  output logic              commit
);
  assign busy   = (cnt_q != '0);
  assign accept = wr_req & ~busy;
  assign commit = (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else if (accept) begin
      cnt_q  <= CNT_W'(NV_CYCLES);
      pend_q <= wr_data;
    end else if (busy) begin
      cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  // Storage cell: no reset, keeps its content through power loss.
  always_ff @(posedge clk) begin
    if (commit) nv_q <= pend_q;
  end
endmodule

// File: rtl/wrc_wiper_reg.sv
module wrc_wiper_reg #(
  parameter int CODE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic [CODE_W-1:0] nv_q,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] wiper_q,
  output logic              ready,
  output logic              recall_evt,
  output logic              wr_acc
);
  import wrc_pkg::*;
  localparam logic [CODE_W-1:0] MID = CODE_W'(mid_code(CODE_W));

  assign recall_evt = supply_ok & ~ready;
  assign wr_acc     = wr_en & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiper_q <= MID;
      ready   <= 1'b0;
    end else if (recall_evt) begin
      wiper_q <= nv_q;
      ready   <= 1'b1;
    end else if (wr_acc) begin
      wiper_q <= wr_data;
    end
  end
endmodule

// File: rtl/wrc_shutdown_out.sv
module wrc_shutdown_out #(
  parameter int CODE_W = 7
) (
  input  logic [CODE_W-1:0] wiper_q,
  input  logic              sd_pin_n,
  input  logic              sd_bit,
  output logic [CODE_W-1:0] tap_sel,
  output logic              shut_o
);
  import wrc_pkg::*;
  assign shut_o = ~sd_pin_n | sd_bit;

  for (genvar i = 0; i < CODE_W; i++) begin : g_tap
    assign tap_sel[i] = tap_bit(wiper_q[i], shut_o);
  end
endmodule

// File: rtl/wiper_recall_ctrl.sv
module wiper_recall_ctrl #(
  parameter int CODE_W    = 7,
  parameter int NV_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              supply_ok,
  input  logic              cs_n,
  input  logic              sd_pin_n,
  input  logic              sd_bit,
  input  logic              wr_wiper_en,
  input  logic              wr_init_en,
  input  logic [CODE_W-1:0] wr_data,
  output logic [CODE_W-1:0] tap_sel,
  output logic              shut_o,
  output logic              nv_busy,
  output logic              standby
);
  localparam int CNT_W = $clog2(NV_CYCLES + 1);

  logic [CODE_W-1:0] nv_q, pend_q, wiper_q;
  logic [CNT_W-1:0]  nv_cnt;
  logic              ready, recall_evt, wr_acc, nv_accept, nv_commit;

  wrc_nv_cell #(.CODE_W(CODE_W), .NV_CYCLES(NV_CYCLES)) u_nv (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_init_en & ready), .wr_data(wr_data),
    .nv_q(nv_q), .pend_q(pend_q), .cnt_q(nv_cnt), .busy(nv_busy),
    .accept(nv_accept), .commit(nv_commit)
  );

  wrc_wiper_reg #(.CODE_W(CODE_W)) u_wiper (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .nv_q(nv_q),
    .wr_en(wr_wiper_en), .wr_data(wr_data), .wiper_q(wiper_q),
    .ready(ready), .recall_evt(recall_evt), .wr_acc(wr_acc)
  );

  wrc_shutdown_out #(.CODE_W(CODE_W)) u_out (
    .wiper_q(wiper_q), .sd_pin_n(sd_pin_n), .sd_bit(sd_bit),
    .tap_sel(tap_sel), .shut_o(shut_o)
  );

  assign standby = cs_n & ~nv_busy;
endmodule

// File: rtl/wrc_checker.sv
module wrc_checker #(
  parameter int CODE_W    = 7,
  parameter int NV_CYCLES = 8,
  localparam int CNT_W    = $clog2(NV_CYCLES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              wr_init_en,
  input logic [CODE_W-1:0] wr_data,
  input logic [CODE_W-1:0] tap_sel,
  input logic              shut_o,
  input logic              nv_busy,
  input logic              standby,
  input logic [CODE_W-1:0] wiper_q,
  input logic [CODE_W-1:0] nv_q,
  input logic [CODE_W-1:0] pend_q,
  input logic [CNT_W-1:0]  nv_cnt,
  input logic              ready,
  input logic              recall_evt,
  input logic              wr_acc,
  input logic              nv_commit
);
  localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

  assert_mid_before_recall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> wiper_q == MID);
  assert_recall_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_evt |=> (wiper_q == $past(nv_q)) && ready);
  assert_tap_follows_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !shut_o |-> tap_sel == wiper_q);
  assert_shut_grounds_tap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shut_o |-> tap_sel == '0);
  assert_code_only_by_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_acc && !recall_evt |=> $stable(wiper_q));
  assert_standby_rule_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !standby);
  assert_standby_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !nv_busy) |-> standby);
  assert_store_only_on_commit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !nv_commit |=> $stable(nv_q));
  assert_commit_value_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_commit |=> nv_q == $past(pend_q));
  assert_busy_countdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |=> nv_cnt == $past(nv_cnt) - CNT_W'(1));
  assert_wiper_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> wiper_q == $past(wr_data));
  assert_busy_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_busy && wr_init_en) |=> $stable(pend_q));
  assert_no_write_unready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !wr_acc && !nv_busy);
endmodule

bind wiper_recall_ctrl wrc_checker #(.CODE_W(CODE_W), .NV_CYCLES(NV_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_init_en(wr_init_en), .wr_data(wr_data),
  .tap_sel(tap_sel), .shut_o(shut_o), .nv_busy(nv_busy), .standby(standby),
  .wiper_q(wiper_q), .nv_q(nv_q), .pend_q(pend_q), .nv_cnt(nv_cnt), .ready(ready),
  .recall_evt(recall_evt), .wr_acc(wr_acc), .nv_commit(nv_commit)
);

// File: tb/wiper_recall_ctrl_bench.sv
module wiper_recall_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W     = 7;
  localparam int NV_CYCLES  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, supply_ok = 1'b0, cs_n = 1'b1, sd_pin_n = 1'b1, sd_bit = 1'b0;
  logic wr_wiper_en = 1'b0, wr_init_en = 1'b0;
  logic [CODE_W-1:0] wr_data = '0;
  logic [CODE_W-1:0] tap_sel;
  logic shut_o, nv_busy, standby;
  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wiper_recall_ctrl #(.CODE_W(CODE_W), .NV_CYCLES(NV_CYCLES)) u_wiper_recall_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
    .sd_pin_n(sd_pin_n), .sd_bit(sd_bit), .wr_wiper_en(wr_wiper_en),
    .wr_init_en(wr_init_en), .wr_data(wr_data), .tap_sel(tap_sel),
    .shut_o(shut_o), .nv_busy(nv_busy), .standby(standby)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Reset with supply low, then power up and recall.
  task automatic power_cycle(input int exp_recall);
    rst_n = 1'b0; supply_ok = 1'b0;
    repeat (3) tick();
    check("R1 reset tap", tap_sel, 'h40);
    rst_n = 1'b1;
    repeat (2) tick();
    check("R1 tap before recall", tap_sel, 'h40);
    supply_ok = 1'b1;
    tick();
    check("R2/R7 recalled tap", tap_sel, exp_recall);
  endtask

  task automatic write_wiper(input int v);
    wr_wiper_en = 1'b1; wr_data = CODE_W'(v);
    tick();
    wr_wiper_en = 1'b0;
  endtask

  task automatic test_nv_program();
    int busy_n = 0;
    cs_n = 1'b1;
    wr_init_en = 1'b1; wr_data = 7'h5A;
    tick();
    wr_init_en = 1'b0;
    check("R6 standby low while busy", standby, 0);
    // R10: second write inside the busy window
    wr_init_en = 1'b1; wr_data = 7'h11;
    busy_n += nv_busy; tick();
    wr_init_en = 1'b0;
    while (nv_busy && busy_n < 100) begin busy_n++; tick(); end
    check("R8 busy length", busy_n, NV_CYCLES);
    check("R6 standby when idle", standby, 1);
    cs_n = 1'b0; #1;
    check("R6 selected not standby", standby, 0);
  endtask

  task automatic test_extremes();
    write_wiper('h00);
    check("R3 code 00h", tap_sel, 'h00);
    write_wiper('h7F);
    check("R3 code 7Fh", tap_sel, 'h7F);
    write_wiper('h2C);
    check("R9 wiper write next clock", tap_sel, 'h2C);
  endtask

  task automatic test_shutdown();
    sd_pin_n = 1'b0; tick();
    check("R4 pin shut flag", shut_o, 1);
    check("R4 pin shut tap", tap_sel, 0);
    sd_pin_n = 1'b1; tick();
    check("R5 restore after pin", tap_sel, 'h2C);
    sd_bit = 1'b1; repeat (3) tick();
    check("R4 bit shut flag", shut_o, 1);
    check("R4 bit shut tap", tap_sel, 0);
    sd_bit = 1'b0; tick();
    check("R5 restore after bit", tap_sel, 'h2C);
    check("R4 released flag", shut_o, 0);
  endtask

  task automatic test_unready_writes();
    rst_n = 1'b0; supply_ok = 1'b0;
    repeat (2) tick();
    rst_n = 1'b1; tick();
    write_wiper('h03);
    check("R11 wiper write ignored", tap_sel, 'h40);
    wr_init_en = 1'b1; wr_data = 7'h44; tick(); wr_init_en = 1'b0;
    check("R11 init write ignored busy", nv_busy, 0);
    supply_ok = 1'b1; tick();
    check("R11 recall unaffected", tap_sel, 'h5A);
    write_wiper('h09); write_wiper('h0A);
    check("R2 recall only once", tap_sel, 'h0A);
  endtask

  task automatic test_abort();
    wr_init_en = 1'b1; wr_data = 7'h33; tick(); wr_init_en = 1'b0;
    repeat (3) tick();
    check("R8 busy mid write", nv_busy, 1);
    power_cycle('h5A);
    check("R7 busy cleared by reset", nv_busy, 0);
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick();
    rst_n = 1'b0; tick();
    check("R1 tap in reset", tap_sel, 'h40);
    check("R8 not busy in reset", nv_busy, 0);
    rst_n = 1'b1; supply_ok = 1'b1; tick();   // first recall: content undefined
    test_nv_program();
    power_cycle('h5A);                         // R7 persistence, R10 rejection
    test_extremes();
    test_shutdown();
    test_unready_writes();
    test_abort();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule